// File: doc/BRIEF.md
# Dual-Limit Interval Timer

This block is a 16-bit up-counting timer that is advanced at most once per service slot, one slot in every four clock cycles. Each advance is triggered by a count event. The event can come from the internal slot itself, from a rising edge on an asynchronous input pin, or from a terminal-count tick supplied by a neighbouring timer that acts as a prescaler. The counter returns to zero in the same update that would bring it to the active limit, so the limit value itself never appears in the count register.

Software sets up the block through four registers: the running count, a primary limit, a secondary limit, and a control word. With one limit in use, the output pin drops low for a single clock after each terminal count. With the alternate-limit bit set, the timer switches between the primary and the secondary limit after each period. The output pin is then high while the primary limit governs and low while the secondary limit governs, so the two limit values set the duty cycle. Each terminal count also produces a one-cycle request pulse.

Top module: `dual_limit_timer`

## Requirements
- R1: After reset, count, both limits and the control word read 0, the output pin is high and the request pulse is low.
- R2: Register addresses are 0 count, 1 primary limit, 2 secondary limit, 3 control. Control bit 0 is enable, bit 1 is continuous, bit 2 is alternate-limit, and bits 4:3 select the source (0 internal, 1 pin, 2 prescaler, 3 none). The count may be written at any time, and a count write wins over a count update in the same cycle.
- R3: Each consumed event adds one to the count. When count+1 equals the active limit, the count becomes 0 instead, so the count never holds the limit value.
- R4: A terminal count raises the request pulse for exactly one cycle. In single-limit mode the output is low in exactly that cycle and high otherwise.
- R5: In alternate-limit mode the output is high for 4×primary cycles and low for 4×secondary cycles, with the internal source.
- R6: A limit value of 0 means 65536 counts.
- R7: The count changes only in a service slot (one clock in four), apart from register writes. With the internal source, one event falls in every slot.
- R8: With the pin source, each synchronised rising edge adds one count, and the count changes no more than 6 clocks after the pin rises.
- R9: With the prescaler source, each tick pulse adds one count.
- R10: With continuous = 0, enable clears at the terminal count that ends a single-limit period, or at the end of the secondary period in alternate mode.
- R11: While enable is 0, or with source 3, events leave the count unchanged.
- R12: Any write to the control word returns the timer to the primary limit, which drives the output high in alternate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 16 | Read data for rdAddr (combinational) |
| extPin | input | 1 | Asynchronous external count input |
| prescaleTick | input | 1 | One-cycle count tick from another timer |
| timerOut | output | 1 | Timer output pin |
| termPulse | output | 1 | One-cycle terminal-count request |

## Verification
The assertions check on every cycle that the count moves only in service slots or on writes, and that the request pulse is a single cycle with the count at zero. They also check that the single-limit output low lasts one cycle, and that in alternate mode the output changes only right after a slot or a control write. Only the bench scenarios can show the exact period and duty-cycle lengths for each limit pair, the behaviour of a zero limit, the pin-to-count latency bound, and the single-shot stop points.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned ADDR_COUNT = 0;
  localparam int unsigned ADDR_LIMA  = 1;
  localparam int unsigned ADDR_LIMB  = 2;
  localparam int unsigned ADDR_CTRL  = 3;

  typedef enum logic [1:0] {
    SRC_SLOT  = 2'd0,
    SRC_PIN   = 2'd1,
    SRC_TICK  = 2'd2,
    SRC_NONE  = 2'd3
  } srcSel_t;

  typedef struct packed {
    srcSel_t src;
    logic    altEn;
    logic    continuous;
    logic    enable;
  } ctrlWord_t;

  typedef struct packed {
    logic inc;
    logic wrap;
    logic flip;
    logic stop;
  } tmrStrobe_t;
endpackage

// File: rtl/timer_ctl.sv
module timer_ctl
  import timer_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SLOT_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlWord_t        ctrl,
  input  logic             useB,
  input  logic [WIDTH-1:0] countQ,
  input  logic [WIDTH-1:0] activeLimit,
  input  logic             cntWrite,
  input  logic             extPin,
  input  logic             prescaleTick,
  output tmrStrobe_t       stb,
  output logic             slot
);
  localparam int PW = (SLOT_DIV > 1) ? $clog2(SLOT_DIV) : 1;
  localparam logic [PW-1:0] LAST_PHASE = PW'(SLOT_DIV - 1);

  logic [PW-1:0] phaseQ;
  logic [SYNC_STAGES:0] syncQ;
  logic pendQ;
  logic extRise;
  logic evtIn;
  logic fire;
  logic hit;
  logic [WIDTH:0] limitEff;
  logic [WIDTH:0] countNext;

  always_ff @(posedge clk) begin
    if (!rstN) phaseQ <= '0;
    else if (phaseQ == LAST_PHASE) phaseQ <= '0;
    else phaseQ <= phaseQ + 1'b1;
  end

  assign slot = (phaseQ == LAST_PHASE);

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else syncQ <= {syncQ[SYNC_STAGES-1:0], extPin};
  end

  assign extRise = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  always_comb begin
    case (ctrl.src)
      SRC_PIN:  evtIn = extRise;
      SRC_TICK: evtIn = prescaleTick;
      default:  evtIn = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= 1'b0;
    else pendQ <= ctrl.enable && !slot && (pendQ || evtIn);
  end

  assign fire = slot && ctrl.enable && !cntWrite &&
                ((ctrl.src == SRC_SLOT) ||
                 ((ctrl.src != SRC_NONE) && (pendQ || evtIn)));

  assign limitEff  = (activeLimit == '0) ? {1'b1, {WIDTH{1'b0}}} : {1'b0, activeLimit};
  assign countNext = {1'b0, countQ} + 1'b1;
  assign hit       = (countNext == limitEff);

  always_comb begin
    stb.inc  = fire && !hit;
    stb.wrap = fire && hit;
    stb.flip = fire && hit && ctrl.altEn;
    stb.stop = fire && hit && !ctrl.continuous && (!ctrl.altEn || useB);
  end
endmodule

// File: rtl/timer_dp.sv
module timer_dp
  import timer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [1:0]       rdAddr,
  input  tmrStrobe_t       stb,
  output logic [WIDTH-1:0] rdData,
  output ctrlWord_t        ctrl,
  output logic [WIDTH-1:0] countQ,
  output logic [WIDTH-1:0] activeLimit,
  output logic             useB,
  output logic             lowPulse
);
  localparam int CW = $bits(ctrlWord_t);

  logic [WIDTH-1:0] limAQ;
  logic [WIDTH-1:0] limBQ;
  logic wrCount;
  logic wrLimA;
  logic wrLimB;
  logic wrCtrl;

  assign wrCount = wrEn && (wrAddr == 2'(ADDR_COUNT));
  assign wrLimA  = wrEn && (wrAddr == 2'(ADDR_LIMA));
  assign wrLimB  = wrEn && (wrAddr == 2'(ADDR_LIMB));
  assign wrCtrl  = wrEn && (wrAddr == 2'(ADDR_CTRL));

  always_ff @(posedge clk) begin
    if (!rstN) countQ <= '0;
    else if (wrCount) countQ <= wrData;
    else if (stb.wrap) countQ <= '0;
    else if (stb.inc) countQ <= countQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limAQ <= '0;
      limBQ <= '0;
    end else begin
      if (wrLimA) limAQ <= wrData;
      if (wrLimB) limBQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrl <= '0;
      useB <= 1'b0;
    end else if (wrCtrl) begin
      ctrl <= ctrlWord_t'(wrData[CW-1:0]);
      useB <= 1'b0;
    end else begin
      if (stb.stop) ctrl.enable <= 1'b0;
      if (stb.flip) useB <= ~useB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lowPulse <= 1'b0;
    else lowPulse <= stb.wrap;
  end

  assign activeLimit = useB ? limBQ : limAQ;

  always_comb begin
    case (rdAddr)
      2'(ADDR_COUNT): rdData = countQ;
      2'(ADDR_LIMA):  rdData = limAQ;
      2'(ADDR_LIMB):  rdData = limBQ;
      default:        rdData = {{(WIDTH-CW){1'b0}}, ctrl};
    endcase
  end
endmodule

// File: rtl/dual_limit_timer.sv
module dual_limit_timer
  import timer_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SLOT_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [WIDTH-1:0] rdData,
  input  logic             extPin,
  input  logic             prescaleTick,
  output logic             timerOut,
  output logic             termPulse
);
  tmrStrobe_t       stb;
  ctrlWord_t        ctrl;
  logic [WIDTH-1:0] countVal;
  logic [WIDTH-1:0] activeLimit;
  logic             useSec;
  logic             lowPulse;
  logic             svcSlot;
  logic             cntWrite;
  logic             altOn;

  assign cntWrite = wrEn && (wrAddr == 2'(ADDR_COUNT));
  assign altOn    = ctrl.altEn;

  timer_ctl #(.WIDTH(WIDTH), .SLOT_DIV(SLOT_DIV), .SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .useB(useSec), .countQ(countVal),
    .activeLimit(activeLimit), .cntWrite(cntWrite), .extPin(extPin),
    .prescaleTick(prescaleTick), .stb(stb), .slot(svcSlot)
  );

  timer_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .stb(stb), .rdData(rdData), .ctrl(ctrl), .countQ(countVal),
    .activeLimit(activeLimit), .useB(useSec), .lowPulse(lowPulse)
  );

  assign timerOut  = altOn ? ~useSec : ~lowPulse;
  assign termPulse = lowPulse;
endmodule

// File: rtl/dual_limit_timer_chk.sv
module dual_limit_timer_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             slot,
  input logic [WIDTH-1:0] countQ,
  input logic             altEn,
  input logic             termPulse,
  input logic             timerOut,
  input logic             wrEn,
  input logic [1:0]       wrAddr
);
  a_r7_slot_only: assert property (@(posedge clk) disable iff (!rstN)
    (!slot && !(wrEn && wrAddr == 2'd0)) |=> $stable(countQ));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    termPulse |=> !termPulse);

  a_r3_zero_on_term: assert property (@(posedge clk) disable iff (!rstN)
    termPulse |-> (countQ == '0));

  a_r4_low_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (!altEn && $fell(timerOut)) |=> timerOut);

  a_r5_alt_edges: assert property (@(posedge clk) disable iff (!rstN)
    (altEn && $past(altEn) && (timerOut != $past(timerOut)))
      |-> ($past(slot) || $past(wrEn && wrAddr == 2'd3)));
endmodule

bind dual_limit_timer dual_limit_timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .slot(svcSlot), .countQ(countVal), .altEn(altOn),
  .termPulse(termPulse), .timerOut(timerOut), .wrEn(wrEn), .wrAddr(wrAddr)
);

// File: tb/sim_dual_limit_timer.sv
module sim_dual_limit_timer;
  logic clk = 0;
  logic rstN = 0;
  logic wrEn = 0;
  logic [1:0] wrAddr = 0;
  logic [15:0] wrData = 0;
  logic [1:0] rdAddr = 0;
  logic [15:0] rdData;
  logic extPin = 0;
  logic prescaleTick = 0;
  logic timerOut;
  logic termPulse;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_limit_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .extPin(extPin), .prescaleTick(prescaleTick),
    .timerOut(timerOut), .termPulse(termPulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rdAddr = a;
    #0.1 d = rdData;
  endtask

  task automatic waitTerm();
    while (!termPulse) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] la, input logic [15:0] lb, input logic [15:0] c);
    wr(3, 0); wr(0, 0); wr(1, la); wr(2, lb); wr(3, c);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); check("R1 reg after reset", v, 0);
    end
    check("R1 out high", timerOut, 1);
    check("R1 pulse low", termPulse, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R2 register read/write
    wr(1, 16'h1234); rd(1, v); check("R2 primary limit", v, 16'h1234);
    wr(2, 16'hBEEF); rd(2, v); check("R2 secondary limit", v, 16'hBEEF);
    wr(3, 16'h0016); rd(3, v); check("R2 control", v, 16'h0016);
    wr(3, 0);

    // R3 R4 R7 single-limit sweep, internal source
    for (int L = 1; L <= 8; L++) begin
      setup(L[15:0], 0, 16'h0003);
      waitTerm();
      for (int p = 0; p < 3; p++) begin
        check("R4 out low at terminal", timerOut, 0);
        rd(0, v); check("R3 count zero after terminal", v, 0);
        n = 0;
        do begin @(negedge clk); n++; if (n == 1) check("R4 out back high", timerOut, 1); end
        while (!termPulse && n < 200);
        check("R7 period is 4 x limit", n, 4 * L);
      end
    end

    // R5 dual-limit sweep
    for (int A = 1; A <= 4; A++) begin
      for (int B = 1; B <= 4; B++) begin
        setup(A[15:0], B[15:0], 16'h0007);
        while (timerOut) @(negedge clk);
        n = 0;
        while (!timerOut && n < 200) begin @(negedge clk); n++; end
        check("R5 low time 4 x secondary", n, 4 * B);
        n = 0;
        while (timerOut && n < 200) begin @(negedge clk); n++; end
        check("R5 high time 4 x primary", n, 4 * A);
      end
    end

    // R12 control write returns to primary
    setup(3, 3, 16'h0007);
    while (timerOut) @(negedge clk);
    wr(3, 16'h0007);
    check("R12 out high after ctrl write", timerOut, 1);

    // R2 count write while running
    setup(1000, 0, 16'h0003);
    repeat (9) @(negedge clk);
    wr(0, 100); rd(0, v); check("R2 count write while running", v, 100);

    // R6 limit 0 is 65536; R3 limit never held
    wr(3, 0); wr(1, 0); wr(0, 16'hFFFE); wr(3, 16'h0003);
    rdAddr = 0;
    n = 0;
    while (rdData != 16'hFFFF && n < 50) begin @(negedge clk); n++; end
    check("R6 count reaches FFFF with zero limit", rdData, 16'hFFFF);
    n = 0;
    while (!termPulse && n < 50) begin @(negedge clk); n++; end
    check("R6 terminal one slot after FFFF", n, 4);
    wr(3, 0); wr(1, 16'hFFFF); wr(0, 16'hFFFE); wr(3, 16'h0003);
    begin
      bit seen = 0;
      rdAddr = 0;
      n = 0;
      while (!termPulse && n < 50) begin
        if (rdData == 16'hFFFF) seen = 1;
        @(negedge clk); n++;
      end
      check("R3 limit value never held", seen, 0);
      check("R3 terminal seen", termPulse, 1);
    end

    // R8 pin source with latency bound
    setup(1000, 0, 16'h000B);
    rdAddr = 0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk); extPin = 1;
      n = 0;
      while (rdData != k[15:0] && n < 20) begin @(negedge clk); n++; end
      check("R8 count per pin edge", rdData, k);
      checks++;
      if (n > 6) begin errors++; $display("FAIL R8 latency: actual %0d expected <= 6", n); end
      repeat (4) @(negedge clk); extPin = 0;
      repeat (6) @(negedge clk);
    end

    // R9 prescaler source
    setup(1000, 0, 16'h0013);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); prescaleTick = 1;
      @(negedge clk); prescaleTick = 0;
      repeat (7) @(negedge clk);
    end
    rd(0, v); check("R9 five ticks counted", v, 5);

    // R11 source none and disabled ignore events
    setup(1000, 0, 16'h001B);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); extPin = 1; prescaleTick = 1;
      @(negedge clk); prescaleTick = 0;
      repeat (6) @(negedge clk); extPin = 0;
      repeat (6) @(negedge clk);
    end
    rd(0, v); check("R11 source none ignores events", v, 0);
    setup(1000, 0, 16'h0002);
    repeat (40) @(negedge clk);
    rd(0, v); check("R11 disabled holds count", v, 0);

    // R10 single-shot
    setup(3, 0, 16'h0001);
    waitTerm();
    rd(3, v); check("R10 enable cleared single", v & 1, 0);
    repeat (30) @(negedge clk);
    rd(0, v); check("R10 count stays after stop", v, 0);
    setup(2, 3, 16'h0005);
    waitTerm();
    rd(3, v); check("R10 enable kept after primary", v & 1, 1);
    @(negedge clk);
    waitTerm();
    rd(3, v); check("R10 enable cleared after secondary", v & 1, 0);
    @(negedge clk);
    check("R10 out high after stop", timerOut, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule